// File: doc/BRIEF.md
# Branch Resolution and Fetch Redirect Unit

This unit steers instruction fetch in a five-stage in-order pipeline whose branches resolve in the decode stage. It holds the fetch PC and the fetch-to-decode pipeline register. Each cycle it chooses the next fetch address. When a branch sits in decode it also decides whether the instruction fetched behind that branch survives. An instruction that does not survive enters decode as an all-zero word with its valid bit cleared, so it writes neither registers nor memory.

Decode supplies four things: a branch-valid flag, a condition kind, two register operands and a signed word offset. The branch target is the address after the branch plus the offset scaled to bytes. A two-bit policy input selects one of four behaviours:
- **Freeze:** every branch costs one bubble.
- **Predict-not-taken:** fetch continues sequentially, and the wrong-path instruction is squashed when the branch is taken.
- **Delayed:** the slot instruction always executes.
- **Annulling delayed:** the slot is treated as assumed-taken, and it is cancelled when the branch falls through.

A global stall overrides everything. While it is asserted, nothing advances.

Top module: `branch_redirect_unit`

## Requirements
- R1: While reset is held, the fetch PC reads 0 and the decode slot reads invalid, with an all-zero instruction.
- R2: With no live branch in decode and no stall, the fetch PC advances by 4 every cycle. The word presented at the fetch input enters decode one cycle later with valid set.
- R3: The branch target is the branch's own PC plus 4, plus the 16-bit offset sign-extended and shifted left by 2. Condition kind 0 is taken when the two operands are equal. Condition kind 1 is taken when the first operand is non-zero.
- R4: In policy 2'b00 (freeze), a live branch raises the fetch-stall output in that cycle. The next decode entry is a bubble. Fetch resumes at the target when the branch is taken, or at the branch PC plus 4 when it is not.
- R5: In policy 2'b01 (predict-not-taken), a branch that is not taken causes no stall and no bubble, and fetch continues at PC plus 4.
- R6: In policy 2'b01, a taken branch moves fetch to the target, and the instruction fetched behind the branch enters decode as a bubble.
- R7: In policy 2'b10 (delayed), the slot instruction after a branch always enters decode valid. Fetch then continues at the target if the branch is taken, or at the slot PC plus 4 if it is not.
- R8: In policy 2'b11 (annulling delayed), a taken branch keeps its slot valid and redirects to the target. A branch that is not taken turns the slot into a bubble, and fetch continues sequentially.
- R9: While the global stall input is high:
  - the fetch-stall output is high;
  - the PC and the decode register hold;
  - a branch in decode takes effect only in the first cycle after the stall drops.
- R10: The policy input is sampled only in cycles with no live branch in decode. A change made while a branch is in decode applies to later branches.
- R11: A branch flag raised while the decode slot holds a bubble is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Branch policy: 0 freeze, 1 predict-not-taken, 2 delayed, 3 annulling delayed |
| hold_i | input | 1 | Global pipeline stall, highest priority |
| if_instr_i | input | INSTW | Instruction word fetched at pc_o |
| dec_br_valid_i | input | 1 | The decode instruction is a conditional branch |
| dec_br_kind_i | input | 1 | Condition: 0 equal operands, 1 first operand non-zero |
| dec_rs_i | input | XLEN | First branch operand |
| dec_rt_i | input | XLEN | Second branch operand |
| dec_off_i | input | OFFW | Signed word offset of the branch |
| pc_o | output | XLEN | Current fetch address |
| if_stall_o | output | 1 | The fetch of this cycle is held or wasted |
| id_instr_o | output | INSTW | Instruction in decode (zero when squashed) |
| id_valid_o | output | 1 | The decode instruction is live |

## Verification
The global stall can fall in the same cycle as a taken branch in decode. This collision decides whether a redirect leaks through a frozen pipeline. The bench provokes it with a taken branch under predict-not-taken while the stall is held, and first checks that the PC and the decode slot do not move. It then drops the stall with the branch still present and checks that the redirect and the squash land exactly one cycle later. A second collision pairs a policy change with a live branch. The bench judges it by seeing the old policy's bubble on that branch and the new policy's kept slot on the next one.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [1:0] {
    POL_FREEZE      = 2'd0,
    POL_PNT         = 2'd1,
    POL_DELAY       = 2'd2,
    POL_DELAY_ANNUL = 2'd3
  } policy_e;

  typedef enum logic {
    COND_EQ  = 1'b0,
    COND_NEZ = 1'b1
  } cond_e;

  typedef struct packed {
    logic take_target;  // fetch goes to branch target
    logic replay;       // fetch returns to branch PC + 4
    logic squash;       // next decode entry becomes a bubble
    logic bubble_stall; // fetch of this cycle is wasted
  } redirect_t;

endpackage

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cond_e            kind,
  input  logic [XLEN-1:0]  rs,
  input  logic [XLEN-1:0]  rt,
  output logic             taken
);

  logic eq_hit;
  logic nz_hit;

  assign eq_hit = (rs == rt);
  assign nz_hit = |rs;

  always_comb begin
    unique case (kind)
      COND_EQ:  taken = eq_hit;
      COND_NEZ: taken = nz_hit;
      default:  taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int XLEN = 32,
  parameter int OFFW = 16
) (
  input  logic [XLEN-1:0] br_pc,
  input  logic [OFFW-1:0] offset,
  output logic [XLEN-1:0] fall_pc,
  output logic [XLEN-1:0] target
);

  localparam int              EXTW = XLEN - OFFW - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] byte_off;

  assign byte_off = {{EXTW{offset[OFFW-1]}}, offset, 2'b00};
  assign fall_pc  = br_pc + STEP;
  assign target   = fall_pc + byte_off;

endmodule

// File: rtl/bru_policy.sv
module bru_policy
  import bru_pkg::*;
(
  input  policy_e   pol,
  input  logic      br_live,
  input  logic      taken,
  output redirect_t act
);

  always_comb begin
    act = '0;
    if (br_live) begin
      act.take_target = taken;
      unique case (pol)
        POL_FREEZE: begin
          act.replay       = !taken;
          act.squash       = 1'b1;
          act.bubble_stall = 1'b1;
        end
        POL_PNT:         act.squash = taken;
        POL_DELAY:       act.squash = 1'b0;
        POL_DELAY_ANNUL: act.squash = !taken;
        default:         act = '0;
      endcase
    end
  end

endmodule

// File: rtl/branch_redirect_unit.sv
module branch_redirect_unit
  import bru_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              OFFW     = 16,
  parameter int              INSTW    = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             hold_i,
  input  logic [INSTW-1:0] if_instr_i,
  input  logic             dec_br_valid_i,
  input  logic             dec_br_kind_i,
  input  logic [XLEN-1:0]  dec_rs_i,
  input  logic [XLEN-1:0]  dec_rt_i,
  input  logic [OFFW-1:0]  dec_off_i,
  output logic [XLEN-1:0]  pc_o,
  output logic             if_stall_o,
  output logic [INSTW-1:0] id_instr_o,
  output logic             id_valid_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0]  pc_q;
  logic [XLEN-1:0]  id_pc_q;
  logic [INSTW-1:0] id_instr_q;
  logic             id_valid_q;
  policy_e          mode_q;

  logic             br_live;
  logic             taken;
  logic [XLEN-1:0]  fall_pc;
  logic [XLEN-1:0]  br_target;
  logic [XLEN-1:0]  pc_next;
  redirect_t        act;

  // a branch flag on a bubble is ignored
  assign br_live = dec_br_valid_i && id_valid_q;

  bru_cond #(.XLEN(XLEN)) u_cond (
    .kind  (cond_e'(dec_br_kind_i)),
    .rs    (dec_rs_i),
    .rt    (dec_rt_i),
    .taken (taken)
  );

  bru_target #(.XLEN(XLEN), .OFFW(OFFW)) u_target (
    .br_pc   (id_pc_q),
    .offset  (dec_off_i),
    .fall_pc (fall_pc),
    .target  (br_target)
  );

  bru_policy u_policy (
    .pol     (mode_q),
    .br_live (br_live),
    .taken   (taken),
    .act     (act)
  );

  always_comb begin
    if (act.take_target)  pc_next = br_target;
    else if (act.replay)  pc_next = fall_pc;
    else                  pc_next = pc_q + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= RESET_PC;
      id_pc_q    <= '0;
      id_instr_q <= '0;
      id_valid_q <= 1'b0;
      mode_q     <= policy_e'(mode_i);
    end else begin
      if (!br_live) mode_q <= policy_e'(mode_i);
      if (!hold_i) begin
        pc_q       <= pc_next;
        id_pc_q    <= pc_q;
        id_instr_q <= act.squash ? '0 : if_instr_i;
        id_valid_q <= !act.squash;
      end
    end
  end

  assign pc_o       = pc_q;
  assign id_instr_o = id_instr_q;
  assign id_valid_o = id_valid_q;
  assign if_stall_o = hold_i || act.bubble_stall;

  // R2: plain sequential flow
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!br_live && !hold_i) |=> (pc_q == $past(pc_q) + STEP));

  // R4: freeze always inserts a bubble
  a_r4_freeze_bubble: assert property (@(posedge clk) disable iff (rst)
    (br_live && mode_q == POL_FREEZE && !hold_i) |=> (!id_valid_q && id_instr_q == '0));

  // R5: not-taken under predict-not-taken flows on
  a_r5_pnt_flow: assert property (@(posedge clk) disable iff (rst)
    (br_live && mode_q == POL_PNT && !taken && !hold_i) |=> (id_valid_q && pc_q == $past(pc_q) + STEP));

  // R6: a taken branch lands on the target in every policy
  a_r6_taken_target: assert property (@(posedge clk) disable iff (rst)
    (br_live && taken && !hold_i) |=> (pc_q == $past(br_target)));

  // R7: the delayed slot survives
  a_r7_slot_kept: assert property (@(posedge clk) disable iff (rst)
    (br_live && mode_q == POL_DELAY && !hold_i) |=> id_valid_q);

  // R8: annul on fall-through
  a_r8_annul_slot: assert property (@(posedge clk) disable iff (rst)
    (br_live && mode_q == POL_DELAY_ANNUL && !taken && !hold_i) |=> !id_valid_q);

  // R9: stall freezes the front end
  a_r9_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> ($stable(pc_q) && $stable(id_valid_q) && $stable(id_instr_q)));

  // R10: policy does not change under a live branch
  a_r10_mode_stable: assert property (@(posedge clk) disable iff (rst)
    br_live |=> $stable(mode_q));

endmodule

// File: tb/sim_branch_redirect_unit.sv
`timescale 1ns/1ps
module sim_branch_redirect_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = 2'd0;
  logic        hold_i = 1'b0;
  logic [31:0] if_instr_i;
  logic        dec_br_valid_i = 1'b0;
  logic        dec_br_kind_i = 1'b0;
  logic [31:0] dec_rs_i = '0;
  logic [31:0] dec_rt_i = '0;
  logic [15:0] dec_off_i = '0;
  logic [31:0] pc_o;
  logic        if_stall_o;
  logic [31:0] id_instr_o;
  logic        id_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  // instruction memory model: word tagged with its address
  assign if_instr_i = {16'hC0DE, pc_o[15:0]};

  function automatic logic [31:0] tag(input logic [31:0] a);
    return {16'hC0DE, a[15:0]};
  endfunction

  branch_redirect_unit u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .hold_i(hold_i),
    .if_instr_i(if_instr_i), .dec_br_valid_i(dec_br_valid_i),
    .dec_br_kind_i(dec_br_kind_i), .dec_rs_i(dec_rs_i), .dec_rt_i(dec_rt_i),
    .dec_off_i(dec_off_i), .pc_o(pc_o), .if_stall_o(if_stall_o),
    .id_instr_o(id_instr_o), .id_valid_o(id_valid_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic br_on(input logic kind, input logic [31:0] rs, input logic [31:0] rt,
                       input logic [15:0] off);
    dec_br_valid_i = 1'b1;
    dec_br_kind_i  = kind;
    dec_rs_i       = rs;
    dec_rt_i       = rt;
    dec_off_i      = off;
  endtask

  task automatic br_off();
    dec_br_valid_i = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    mode_i = m; hold_i = 1'b0; br_off(); rst = 1'b1;
    tick(); tick();
    chk("R1 pc", pc_o, 32'h0);
    chk("R1 valid", {31'b0, id_valid_o}, 32'h0);
    chk("R1 instr", id_instr_o, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_seq();
    do_reset(2'd1);
    for (int i = 1; i <= 3; i++) begin
      tick();
      chk("R2 pc", pc_o, 32'(4 * i));
      chk("R2 id", id_instr_o, tag(32'(4 * (i - 1))));
      chk("R2 valid", {31'b0, id_valid_o}, 32'h1);
    end
  endtask

  task automatic t_freeze();
    do_reset(2'd0);
    tick();                          // branch @0 in decode, pc=4
    br_on(1'b0, 32'd5, 32'd5, 16'd3); // taken, target 16
    #1 chk("R4 stall taken", {31'b0, if_stall_o}, 32'h1);
    tick(); br_off();
    chk("R4 R3 pc target", pc_o, 32'd16);
    chk("R4 bubble", {31'b0, id_valid_o}, 32'h0);
    chk("R4 bubble word", id_instr_o, 32'h0);
    tick();
    chk("R4 target in id", id_instr_o, tag(32'd16));
    do_reset(2'd0);
    tick();
    br_on(1'b1, 32'd0, 32'd9, 16'd3); // kind NEZ with zero: not taken
    #1 chk("R4 stall nt", {31'b0, if_stall_o}, 32'h1);
    tick(); br_off();
    chk("R4 replay pc", pc_o, 32'd4);
    chk("R4 nt bubble", {31'b0, id_valid_o}, 32'h0);
    tick();
    chk("R4 replay id", id_instr_o, tag(32'd4));
    chk("R4 replay valid", {31'b0, id_valid_o}, 32'h1);
  endtask

  task automatic t_pnt();
    do_reset(2'd1);
    tick();
    br_on(1'b0, 32'd1, 32'd2, 16'd3); // not equal: not taken
    #1 chk("R5 no stall", {31'b0, if_stall_o}, 32'h0);
    tick(); br_off();
    chk("R5 pc", pc_o, 32'd8);
    chk("R5 slot id", id_instr_o, tag(32'd4));
    chk("R5 slot valid", {31'b0, id_valid_o}, 32'h1);
    do_reset(2'd1);
    tick(); tick(); tick();          // branch @8 in decode, pc=12
    br_on(1'b1, 32'd7, 32'd0, 16'hFFFE); // taken, target 12-8=4
    tick(); br_off();
    chk("R6 R3 neg target", pc_o, 32'd4);
    chk("R6 squash", {31'b0, id_valid_o}, 32'h0);
    tick();
    chk("R6 target id", id_instr_o, tag(32'd4));
  endtask

  task automatic t_delay();
    do_reset(2'd2);
    tick();
    br_on(1'b0, 32'd3, 32'd3, 16'd4); // taken, target 20
    tick(); br_off();
    chk("R7 taken pc", pc_o, 32'd20);
    chk("R7 slot kept", id_instr_o, tag(32'd4));
    chk("R7 slot valid", {31'b0, id_valid_o}, 32'h1);
    do_reset(2'd2);
    tick();
    br_on(1'b0, 32'd3, 32'd4, 16'd4);
    tick(); br_off();
    chk("R7 nt pc", pc_o, 32'd8);
    chk("R7 nt slot valid", {31'b0, id_valid_o}, 32'h1);
  endtask

  task automatic t_annul();
    do_reset(2'd3);
    tick();
    br_on(1'b1, 32'd1, 32'd0, 16'd4);
    tick(); br_off();
    chk("R8 taken pc", pc_o, 32'd20);
    chk("R8 taken slot", {31'b0, id_valid_o}, 32'h1);
    do_reset(2'd3);
    tick();
    br_on(1'b1, 32'd0, 32'd0, 16'd4);
    tick(); br_off();
    chk("R8 nt pc", pc_o, 32'd8);
    chk("R8 annulled", {31'b0, id_valid_o}, 32'h0);
  endtask

  task automatic t_hold();
    do_reset(2'd1);
    tick();
    hold_i = 1'b1;
    br_on(1'b0, 32'd6, 32'd6, 16'd3);
    #1 chk("R9 stall out", {31'b0, if_stall_o}, 32'h1);
    tick(); tick();
    chk("R9 pc held", pc_o, 32'd4);
    chk("R9 id held", id_instr_o, tag(32'd0));
    chk("R9 id valid held", {31'b0, id_valid_o}, 32'h1);
    hold_i = 1'b0;
    tick(); br_off();
    chk("R9 late redirect", pc_o, 32'd16);
    chk("R9 late squash", {31'b0, id_valid_o}, 32'h0);
  endtask

  task automatic t_mode();
    do_reset(2'd0);
    tick();
    br_on(1'b0, 32'd2, 32'd2, 16'd3);
    mode_i = 2'd2;                   // change while branch live
    tick(); br_off();
    chk("R10 old policy bubble", {31'b0, id_valid_o}, 32'h0);
    chk("R10 pc", pc_o, 32'd16);
    tick();                          // branch @16 in decode
    br_on(1'b0, 32'd2, 32'd2, 16'd2); // target 28
    tick(); br_off();
    chk("R10 new policy pc", pc_o, 32'd28);
    chk("R10 new policy slot", {31'b0, id_valid_o}, 32'h1);
  endtask

  task automatic t_ignore();
    do_reset(2'd1);
    tick();
    br_on(1'b0, 32'd1, 32'd1, 16'd3); // taken, target 16
    tick();
    br_on(1'b0, 32'd1, 32'd1, 16'd10); // flag on bubble
    tick(); br_off();
    chk("R11 ignored pc", pc_o, 32'd20);
    chk("R11 target id", id_instr_o, tag(32'd16));
  endtask

  initial begin
    t_seq();
    t_freeze();
    t_pnt();
    t_delay();
    t_annul();
    t_hold();
    t_mode();
    t_ignore();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule